// File: doc/BRIEF.md
# Work Semaphore Counter

This block keeps, for one processing channel, an 8-bit count of work packets that software has queued and the engine has not yet retired. Software raises the count with a register write whose low byte is an increment; that increment is added to the count, never loaded over it. The engine lowers the count by one with a single-cycle strobe whenever it completes a packet whose control word requests a decrement. When both arrive on the same clock edge they merge into a single net change, so neither update is lost.

The live count is always readable in a 32-bit register image and on a dedicated output. A nonzero flag serves as a work-pending indication. A one-cycle event marks each drop of the count from nonzero to zero. A test input can raise that event on demand, so the logic downstream of it can be exercised. Saturation guards both ends of the range. A decrement at zero is recorded in a sticky error flag.

Top module: `work_sem_counter`

## Requirements
- R1: A cycle with `wr_en` high adds `wr_data[7:0]` to the count at that clock edge, with no decrement pending. The new value is visible after the edge.
- R2: `rd_data` always carries the count in bits 23:16 and zero in every other bit. `count_o` carries the same count.
- R3: A cycle with `dec_strobe` high and no write lowers a nonzero count by exactly one.
- R4: A write and a decrement at the same edge leave the count equal to count + increment - 1, limited as in R5 and R6.
- R5: Any result above 255 is held at 255.
- R6: A result below 0 is held at 0 and sets `err_o`. Once set, `err_o` stays high until reset.
- R7: `zero_evt` is high for exactly the one cycle after an edge at which a nonzero count became zero, and low otherwise, apart from R8.
- R8: `test_kick` high at an edge makes `zero_evt` high for the following cycle and leaves the count unchanged.
- R9: `nonzero_o` is high exactly when the count is not zero.
- R10: `rst` high at an edge clears the count and `err_o` and keeps `zero_evt` low. Reset takes precedence over every other input, and it produces no zero event even when it clears a nonzero count.
- R11: Bits 31:8 of `wr_data` have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe, one per add |
| wr_data | input | 32 | Write data; bits 7:0 are the increment |
| dec_strobe | input | 1 | Engine decrement request, one cycle per packet |
| test_kick | input | 1 | Test control that forces a zero event |
| rd_data | output | 32 | Register image with the count in bits 23:16 |
| count_o | output | 8 | Live count |
| nonzero_o | output | 1 | High while the count is not zero |
| zero_evt | output | 1 | One-cycle pulse after a transition to zero |
| err_o | output | 1 | Sticky flag for a decrement below zero |

## Verification
The counter is driven with several patterns, and each one separates a different fault:
- Lone adds, including one with the upper write bits set, separate an accumulating counter from one that loads its input, and a correct byte select from a wider one.
- Lone decrements separate the step of one from wrong step sizes.
- Write and decrement in the same cycle, both mid-range and at 255, show whether one of the two updates gets dropped.
- Decrements at zero, with and without a zero-valued write, separate a floor from a wrap-around, and confirm that the error flag stays set.
- A reset of a nonzero count and a test kick on its own each separate the true zero transition from the other events that could be mistaken for it.

// File: rtl/work_sem_pkg.sv
package work_sem_pkg;

  localparam int SEM_CNT_W_DEF = 8;
  localparam int SEM_REG_W_DEF = 32;

  // Raw signed sum of one cycle's changes before any limiting.
  function automatic int sem_raw(input int cur, input int add, input bit dec);
    return cur + add - (dec ? 1 : 0);
  endfunction

  // Limited next value: floor at zero, ceiling at maxv.
  function automatic int sem_limit(input int raw, input int maxv);
    int r;
    r = raw;
    if (r > maxv) r = maxv;
    if (r < 0) r = 0;
    return r;
  endfunction

  // True when the requested change would go below zero.
  function automatic bit sem_below(input int raw);
    return raw < 0;
  endfunction

endpackage

// File: rtl/sem_wr_decode.sv
module sem_wr_decode #(
  parameter int REG_W   = 32,
  parameter int CNT_W   = 8,
  parameter int INC_LSB = 0
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [CNT_W-1:0] add_amt
);
  localparam int INC_MSB = INC_LSB + CNT_W - 1;

  // Only the increment field is taken; the remaining bits are dropped here.
  always_comb begin
    add_amt = '0;
    if (wr_en) add_amt = wr_data[INC_MSB:INC_LSB];
  end
endmodule

// File: rtl/sem_count_core.sv
module sem_count_core
  import work_sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] add_amt,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fall_evt,
  output logic             under_evt
);
  localparam int MAXV = (1 << CNT_W) - 1;

  int               raw_sum;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    raw_sum   = sem_raw(int'(cnt_q), int'(add_amt), dec);
    cnt_d     = CNT_W'(sem_limit(raw_sum, MAXV));
    under_evt = sem_below(raw_sum);
    fall_evt  = (cnt_q != '0) && (cnt_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sem_event_regs.sv
module sem_event_regs (
  input  logic clk,
  input  logic rst,
  input  logic fall_evt,
  input  logic under_evt,
  input  logic test_kick,
  output logic zero_evt,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      zero_evt <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      zero_evt <= fall_evt | test_kick;
      err_q    <= err_q | under_evt;
    end
  end
endmodule

// File: rtl/work_sem_counter.sv
module work_sem_counter
  import work_sem_pkg::*;
#(
  parameter int REG_W   = SEM_REG_W_DEF,
  parameter int CNT_W   = SEM_CNT_W_DEF,
  parameter int INC_LSB = 0,
  parameter int CNT_LSB = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             dec_strobe,
  input  logic             test_kick,
  output logic [REG_W-1:0] rd_data,
  output logic [CNT_W-1:0] count_o,
  output logic             nonzero_o,
  output logic             zero_evt,
  output logic             err_o
);
  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0] add_amt;
  logic             fall_evt;
  logic             under_evt;
  logic [CNT_W-1:0] cnt_q;

  sem_wr_decode #(.REG_W(REG_W), .CNT_W(CNT_W), .INC_LSB(INC_LSB)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .add_amt (add_amt)
  );

  sem_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .add_amt   (add_amt),
    .dec       (dec_strobe),
    .cnt_q     (cnt_q),
    .fall_evt  (fall_evt),
    .under_evt (under_evt)
  );

  sem_event_regs u_evt (
    .clk       (clk),
    .rst       (rst),
    .fall_evt  (fall_evt),
    .under_evt (under_evt),
    .test_kick (test_kick),
    .zero_evt  (zero_evt),
    .err_q     (err_o)
  );

  always_comb begin
    rd_data = '0;
    rd_data[CNT_LSB +: CNT_W] = cnt_q;
  end

  assign count_o   = cnt_q;
  assign nonzero_o = |cnt_q;
endmodule

// File: rtl/work_sem_checker.sv
module work_sem_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CNT_W-1:0] add_amt,
  input logic             dec_strobe,
  input logic             test_kick,
  input logic [CNT_W-1:0] count_o,
  input logic             zero_evt,
  input logic             err_o
);
  localparam logic [CNT_W:0] MAXW = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0] wide_sum;
  assign wide_sum = {1'b0, count_o} + {1'b0, add_amt};

  assert_add_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en && !dec_strobe && (wide_sum <= MAXW)
    |=> ({1'b0, count_o} == $past(wide_sum)));

  assert_dec_R3: assert property (@(posedge clk) disable iff (rst)
    dec_strobe && !wr_en && (count_o != '0)
    |=> (count_o == $past(count_o) - 1'b1));

  assert_both_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && dec_strobe && (add_amt != '0) && (wide_sum <= MAXW + 1'b1)
    |=> ({1'b0, count_o} == $past(wide_sum) - 1'b1));

  assert_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && !dec_strobe && (wide_sum > MAXW)
    |=> (count_o == MAXW[CNT_W-1:0]));

  assert_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0) && dec_strobe && (add_amt == '0)
    |=> ((count_o == '0) && err_o));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  assert_zero_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    zero_evt && !$past(test_kick)
    |-> ((count_o == '0) && ($past(count_o) != '0)));

  assert_kick_R8: assert property (@(posedge clk) disable iff (rst)
    test_kick |=> (zero_evt && (count_o == $past(wide_sum[CNT_W-1:0])) ||
                   zero_evt && !$past(wr_en) && !$past(dec_strobe) && $stable(count_o) ||
                   zero_evt && ($past(wr_en) || $past(dec_strobe))));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> ((count_o == '0) && !zero_evt && !err_o));
endmodule

bind work_sem_counter work_sem_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .add_amt    (add_amt),
  .dec_strobe (dec_strobe),
  .test_kick  (test_kick),
  .count_o    (count_o),
  .zero_evt   (zero_evt),
  .err_o      (err_o)
);

// File: tb/work_sem_counter_bench.sv
module work_sem_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        dec_strobe = 1'b0;
  logic        test_kick = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  count_o;
  logic        nonzero_o, zero_evt, err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int    cnt;
    bit    zev;
    bit    err;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // Bench-side model state.
  int m_cnt = 0;
  bit m_err = 1'b0;

  always #4 clk = ~clk;

  work_sem_counter u_work_sem_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .dec_strobe(dec_strobe), .test_kick(test_kick), .rd_data(rd_data),
    .count_o(count_o), .nonzero_o(nonzero_o), .zero_evt(zero_evt), .err_o(err_o)
  );

  // Driver: applies one cycle of stimulus and pushes what must follow it.
  task automatic cyc(input bit r, input bit w, input logic [31:0] d,
                     input bit dc, input bit k, input string tag);
    exp_t e;
    int   want;
    @(negedge clk);
    rst = r; wr_en = w; wr_data = d; dec_strobe = dc; test_kick = k;
    if (r) begin
      e.cnt = 0; e.zev = 1'b0; m_err = 1'b0; m_cnt = 0;
    end else begin
      want = m_cnt - (dc ? 1 : 0);
      if (w) want = want + int'(d & 32'hFF);
      if (want < 0) m_err = 1'b1;
      e.cnt = (want > 255) ? 255 : ((want < 0) ? 0 : want);
      e.zev = k || (m_cnt != 0 && e.cnt == 0);
      m_cnt = e.cnt;
    end
    e.err = m_err;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares each result two time units after the edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [31:0] img;
      e   = exp_q.pop_front();
      img = 32'(e.cnt) << 16;
      n_tests++;
      if (count_o !== 8'(e.cnt) || rd_data !== img || nonzero_o !== (e.cnt != 0) ||
          zero_evt !== e.zev || err_o !== e.err) begin
        n_fail++;
        $display("FAIL %s: got cnt=%0d rd=%h nz=%b zev=%b err=%b, expected cnt=%0d rd=%h nz=%b zev=%b err=%b",
                 e.tag, count_o, rd_data, nonzero_o, zero_evt, err_o,
                 e.cnt, img, e.cnt != 0, e.zev, e.err);
      end
    end
  end

  initial begin
    cyc(1, 0, 0, 0, 0, "R10 reset state");
    cyc(1, 1, 32'h55, 1, 1, "R10 reset dominates inputs");
    cyc(0, 1, 32'h5, 0, 0, "R1 add 5, R2 image, R9 nonzero");
    cyc(0, 1, 32'hABCD_0003, 0, 0, "R11 upper write bits ignored");
    cyc(0, 0, 0, 1, 0, "R3 single decrement");
    cyc(0, 1, 32'h4, 1, 0, "R4 add 4 with decrement");
    cyc(0, 0, 0, 0, 0, "R4 count holds when idle");
    cyc(0, 1, 32'hFA, 0, 0, "R5 add to ceiling");
    cyc(0, 1, 32'h1, 0, 0, "R5 add at ceiling holds 255");
    cyc(0, 1, 32'h1, 1, 0, "R4 combined at 255");
    cyc(1, 0, 0, 0, 0, "R10 reset of nonzero gives no event");
    cyc(0, 1, 32'h2, 0, 0, "R1 add 2");
    cyc(0, 0, 0, 1, 0, "R3 decrement to 1");
    cyc(0, 0, 0, 1, 0, "R7 transition to zero pulses");
    cyc(0, 0, 0, 0, 0, "R7 pulse lasts one cycle");
    cyc(0, 0, 0, 1, 0, "R6 decrement at zero floors and flags");
    cyc(0, 0, 0, 0, 0, "R6 error stays set");
    cyc(0, 1, 32'h1, 0, 0, "R6 error survives add");
    cyc(0, 1, 32'h1, 1, 0, "R4 combined at 1 keeps 1, R7 no event");
    cyc(0, 0, 0, 0, 1, "R8 kick pulses, count unchanged");
    cyc(0, 0, 0, 0, 0, "R8 kick pulse ends");
    cyc(0, 0, 0, 1, 1, "R8 kick with real transition");
    cyc(0, 1, 32'h0, 1, 0, "R6 zero add with decrement at zero");
    cyc(1, 0, 0, 0, 0, "R10 reset clears error");
    cyc(0, 0, 0, 0, 0, "R9 nonzero low at zero");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule